// File: doc/BRIEF.md
# Lookahead Head Cache Replenisher

This block sits on the read side of a large packet buffer that keeps many FIFO queues in wide, slow bulk memory. A scheduler asks for one cell per slot from any of the queues. The block answers every request from a small per-queue head cache. It refills that cache one whole block of `BLK` cells at a time from bulk memory. Requests first pass through a lookahead delay line. While a request waits in that line, the block inspects everything queued behind it and decides which queue to refill next. When the request reaches the end of the line, its cell is already in the cache.

Because of this, every request gets its cell after the same fixed delay. Refills do not react to misses. They are scheduled against the queue whose first shortfall lies nearest to the output. The lookahead part of the delay is `NQ*(BLK-1)+1` slots, and the bulk read latency `RD_LAT` is added to it. The sum is `DEPTH`. This latency buys a head cache far smaller than a zero-latency design would need.

None of the interfaces has back-pressure, and the block has no ready signals. A fixed delay cannot be kept if any stage may stall. The requester may present a request in any cycle. The bulk memory must answer every read exactly `RD_LAT` cycles after `rd_valid`. The block accepts a response in any cycle. The consumer must take `out_valid` whenever it is high.

Top module: `hcr_head_cache`

## Requirements
- R1: After reset, `out_valid` and `rd_valid` are low, and they stay low until requests arrive.
- R2: A request sampled with `req_valid` high at clock edge e produces exactly one cell with `out_valid` high after edge e+DEPTH, where DEPTH = NQ*(BLK-1)+1+RD_LAT (11 with the defaults). `out_valid` is low in every cycle that no such request accounts for.
- R3: For each queue, the cells leave in the order they were fetched. Within a block, slice i of `rsp_data` (bits i*CW upward) precedes slice i+1. `out_qid` equals the queue of the request.
- R4: Two bulk reads are never closer than BLK cycles apart.
- R5: A read is issued only for a queue whose cached plus in-flight cells fall short of its requests in the delay line. Among the queues that fall short, the block refills the one whose first uncovered request is oldest. Ties go to the lowest queue id.
- R6: A response writes all BLK cells of its block into that queue's circular head store and raises its fill count by BLK. Each departure lowers the fill count by one.
- R7: No departure ever finds its queue's head store empty, for any request stream.
- R8: A head store never holds more than DEPTH+BLK cells, and a queue's cached plus in-flight cells never exceed that bound.
- R9: Over a stream that drains fully, each queue receives exactly ceil(requests/BLK) reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Scheduler request present |
| req_qid | input | QW | Queue requested |
| rd_valid | output | 1 | Bulk block read issued |
| rd_qid | output | QW | Queue whose next block is read |
| rsp_valid | input | 1 | Bulk block returned |
| rsp_qid | input | QW | Queue of returned block |
| rsp_data | input | BLK*CW | Returned cells, oldest in the low slice |
| out_valid | output | 1 | Departing cell present |
| out_qid | output | QW | Queue of departing cell |
| out_data | output | CW | Departing cell |

## Verification
A request driven before edge e must show up after edge e+DEPTH. A read seen after edge c must be answered so that the block samples the response at edge c+RD_LAT. The bench runs a reference model keyed by cycle number. The model stores each expected cell under the cycle in which it is due. It compares `out_valid`, `out_qid` and `out_data` at every falling edge, where a missing entry means an idle output. The spacing between reads, the first refill order after reset and the final per-queue read totals are checked against the same cycle count.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  localparam int unsigned DEF_NQ     = 4;
  localparam int unsigned DEF_BLK    = 3;
  localparam int unsigned DEF_CW     = 8;
  localparam int unsigned DEF_RD_LAT = 2;

  // Lookahead window plus bulk read latency: fixed request-to-cell delay.
  function automatic int unsigned pipe_depth(input int unsigned nq,
                                             input int unsigned blk,
                                             input int unsigned rdl);
    return nq * (blk - 1) + 1 + rdl;
  endfunction

endpackage

// File: rtl/hcr_req_pipe.sv
module hcr_req_pipe #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned QW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [QW-1:0]             in_qid,
  output logic [DEPTH-1:0]          stg_valid,
  output logic [DEPTH-1:0][QW-1:0]  stg_qid
);

  // Stage 0 holds the newest request, stage DEPTH-1 departs this cycle.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_valid[s] <= 1'b0;
          stg_qid[s]   <= '0;
        end else begin
          stg_valid[s] <= in_valid;
          stg_qid[s]   <= in_qid;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_valid[s] <= 1'b0;
          stg_qid[s]   <= '0;
        end else begin
          stg_valid[s] <= stg_valid[s-1];
          stg_qid[s]   <= stg_qid[s-1];
        end
      end
    end
  end

endmodule

// File: rtl/hcr_refill_sel.sv
module hcr_refill_sel #(
  parameter int unsigned NQ    = 4,
  parameter int unsigned BLK   = 3,
  parameter int unsigned DEPTH = 11,
  parameter int unsigned QW    = 2,
  parameter int unsigned CAP   = 14,
  parameter int unsigned CNTW  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          stg_valid,
  input  logic [DEPTH-1:0][QW-1:0]  stg_qid,
  output logic                      rd_valid,
  output logic [QW-1:0]             rd_qid
);

  localparam int unsigned DW = $clog2(DEPTH + 1);
  localparam int unsigned GW = (BLK > 2) ? $clog2(BLK) : 1;
  localparam int unsigned SW = $clog2(BLK + 1);

  // Cells cached plus cells already requested from bulk memory, per queue.
  logic [NQ-1:0][CNTW-1:0] committed;
  logic [NQ-1:0]           short_q;
  logic [NQ-1:0][DW-1:0]   urg;
  logic                    pick_v;
  logic [QW-1:0]           pick_q;
  logic [DW-1:0]           best;
  logic                    issue;
  logic [GW-1:0]           gap;
  logic                    dep;
  logic [QW-1:0]           dep_q;

  assign dep   = stg_valid[DEPTH-1];
  assign dep_q = stg_qid[DEPTH-1];

  // Walk the delay line from oldest to newest and find each queue's first
  // request that its committed cells cannot cover.
  always_comb begin
    logic [CNTW:0] cum;
    for (int q = 0; q < NQ; q++) begin
      short_q[q] = 1'b0;
      urg[q]     = '1;
      cum        = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (stg_valid[DEPTH-1-k] && (stg_qid[DEPTH-1-k] == QW'(q))) begin
          cum = cum + 1'b1;
          if (!short_q[q] && (cum > {1'b0, committed[q]})) begin
            short_q[q] = 1'b1;
            urg[q]     = DW'(k);
          end
        end
      end
    end
  end

  // Earliest shortfall wins; strict compare keeps the lowest id on a tie.
  always_comb begin
    pick_v = 1'b0;
    pick_q = '0;
    best   = '1;
    for (int q = 0; q < NQ; q++) begin
      if (short_q[q] && (!pick_v || (urg[q] < best))) begin
        pick_v = 1'b1;
        pick_q = QW'(q);
        best   = urg[q];
      end
    end
  end

  assign issue = pick_v && (gap == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_qid   <= '0;
      gap      <= '0;
    end else begin
      rd_valid <= issue;
      if (issue) rd_qid <= pick_q;
      if (issue)            gap <= GW'(BLK - 1);
      else if (gap != '0)   gap <= gap - 1'b1;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_commit
    logic add_blk;
    logic sub_one;
    assign add_blk = issue && (pick_q == QW'(q));
    assign sub_one = dep && (dep_q == QW'(q));
    always_ff @(posedge clk) begin
      if (!rst_n) committed[q] <= '0;
      else if (add_blk && !sub_one) committed[q] <= committed[q] + CNTW'(BLK);
      else if (add_blk && sub_one)  committed[q] <= committed[q] + CNTW'(BLK - 1);
      else if (sub_one)             committed[q] <= committed[q] - 1'b1;
    end

    // R8: committed cells stay within the store size.
    assert_commit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      committed[q] <= CNTW'(CAP));
  end

  // Independent spacing counter for the issue-rate check.
  logic [SW-1:0] since_issue;
  always_ff @(posedge clk) begin
    if (!rst_n)                       since_issue <= SW'(BLK);
    else if (issue)                   since_issue <= SW'(1);
    else if (since_issue < SW'(BLK))  since_issue <= since_issue + 1'b1;
  end

  // R4: reads are at least BLK cycles apart.
  assert_issue_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (since_issue >= SW'(BLK)));

endmodule

// File: rtl/hcr_queue_store.sv
module hcr_queue_store #(
  parameter int unsigned BLK  = 3,
  parameter int unsigned CW   = 8,
  parameter int unsigned CAP  = 14,
  parameter int unsigned PW   = 4,
  parameter int unsigned CNTW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [BLK*CW-1:0]  push_data,
  input  logic               pop,
  output logic [CW-1:0]      head,
  output logic [CNTW-1:0]    cnt
);

  logic [CW-1:0] mem [CAP];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p,
                                            input int unsigned    n);
    int unsigned s;
    s = int'(p) + n;
    if (s >= CAP) s = s - CAP;
    return PW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < BLK; i++) begin
        mem[ptr_add(wr_ptr, i)] <= push_data[i*CW +: CW];
      end
    end
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_add(wr_ptr, BLK);
      if (pop)  rd_ptr <= ptr_add(rd_ptr, 1);
      if (push && !pop)      cnt <= cnt + CNTW'(BLK);
      else if (push && pop)  cnt <= cnt + CNTW'(BLK - 1);
      else if (pop)          cnt <= cnt - 1'b1;
    end
  end

  // R7: a departure always finds a cached cell.
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));

  // R8: a refill always fits.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ({1'b0, cnt} + (CNTW+1)'(BLK) <= (CNTW+1)'(CAP)));

endmodule

// File: rtl/hcr_head_cache.sv
module hcr_head_cache #(
  parameter int unsigned NQ     = hcr_pkg::DEF_NQ,
  parameter int unsigned BLK    = hcr_pkg::DEF_BLK,
  parameter int unsigned CW     = hcr_pkg::DEF_CW,
  parameter int unsigned RD_LAT = hcr_pkg::DEF_RD_LAT,
  localparam int unsigned QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [QW-1:0]      req_qid,
  output logic               rd_valid,
  output logic [QW-1:0]      rd_qid,
  input  logic               rsp_valid,
  input  logic [QW-1:0]      rsp_qid,
  input  logic [BLK*CW-1:0]  rsp_data,
  output logic               out_valid,
  output logic [QW-1:0]      out_qid,
  output logic [CW-1:0]      out_data
);

  localparam int unsigned DEPTH = hcr_pkg::pipe_depth(NQ, BLK, RD_LAT);
  localparam int unsigned CAP   = DEPTH + BLK;
  localparam int unsigned PW    = $clog2(CAP);
  localparam int unsigned CNTW  = $clog2(CAP + 1);

  logic [DEPTH-1:0]         stg_valid;
  logic [DEPTH-1:0][QW-1:0] stg_qid;
  logic [NQ-1:0][CW-1:0]    q_head;
  logic [NQ-1:0][CNTW-1:0]  q_cnt;
  logic                     dep;
  logic [QW-1:0]            dep_q;

  hcr_req_pipe #(.DEPTH(DEPTH), .QW(QW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_qid    (req_qid),
    .stg_valid (stg_valid),
    .stg_qid   (stg_qid)
  );

  hcr_refill_sel #(
    .NQ(NQ), .BLK(BLK), .DEPTH(DEPTH), .QW(QW), .CAP(CAP), .CNTW(CNTW)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .stg_valid (stg_valid),
    .stg_qid   (stg_qid),
    .rd_valid  (rd_valid),
    .rd_qid    (rd_qid)
  );

  assign dep   = stg_valid[DEPTH-1];
  assign dep_q = stg_qid[DEPTH-1];

  for (genvar q = 0; q < NQ; q++) begin : g_store
    logic push_q;
    logic pop_q;
    assign push_q = rsp_valid && (rsp_qid == QW'(q));
    assign pop_q  = dep && (dep_q == QW'(q));
    hcr_queue_store #(
      .BLK(BLK), .CW(CW), .CAP(CAP), .PW(PW), .CNTW(CNTW)
    ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_q),
      .push_data (rsp_data),
      .pop       (pop_q),
      .head      (q_head[q]),
      .cnt       (q_cnt[q])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_qid   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= dep;
      if (dep) begin
        out_qid  <= dep_q;
        out_data <= q_head[dep_q];
      end
    end
  end

endmodule

// File: tb/sim_hcr_head_cache.sv
module sim_hcr_head_cache;

  localparam int CLK_NS = 10;
  localparam int NQ     = 4;
  localparam int BLK    = 3;
  localparam int CW     = 8;
  localparam int RDL    = 2;
  localparam int QW     = 2;
  localparam int IW     = CW - QW;
  localparam int DEPTH  = NQ * (BLK - 1) + 1 + RDL;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic [QW-1:0]      req_qid = '0;
  logic               rd_valid;
  logic [QW-1:0]      rd_qid;
  logic               rsp_valid = 1'b0;
  logic [QW-1:0]      rsp_qid = '0;
  logic [BLK*CW-1:0]  rsp_data = '0;
  logic               out_valid;
  logic [QW-1:0]      out_qid;
  logic [CW-1:0]      out_data;

  hcr_head_cache #(.NQ(NQ), .BLK(BLK), .CW(CW), .RD_LAT(RDL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_qid(req_qid),
    .rd_valid(rd_valid), .rd_qid(rd_qid), .rsp_valid(rsp_valid),
    .rsp_qid(rsp_qid), .rsp_data(rsp_data), .out_valid(out_valid),
    .out_qid(out_qid), .out_data(out_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference state: expected departures and bulk replies keyed by cycle.
  logic [CW-1:0] exp_d [int];
  logic [QW-1:0] exp_q [int];
  logic [QW-1:0] rsp_at [int];
  int nxt_dep [NQ];
  int nxt_blk [NQ];
  int reads_q [NQ];
  int req_q   [NQ];
  int rd_log  [$];
  int last_rd = -1000;
  bit log_rd  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc=%0d %s got %0d exp %0d", req, cyc, what, got, exp);
    end
  endtask

  // One slot: check outputs after the last edge, then drive the next inputs.
  task automatic step(input bit v, input int q);
    @(negedge clk);
    if (exp_d.exists(cyc)) begin
      check(out_valid == 1'b1, "R2", "out_valid", out_valid, 1);
      check(out_qid == exp_q[cyc], "R3", "out_qid", out_qid, exp_q[cyc]);
      check(out_data == exp_d[cyc], "R3", "out_data", out_data, exp_d[cyc]);
      exp_d.delete(cyc);
      exp_q.delete(cyc);
    end else begin
      check(out_valid == 1'b0, "R2", "idle out_valid", out_valid, 0);
    end
    if (rd_valid) begin
      check(cyc - last_rd >= BLK, "R4", "read spacing", cyc - last_rd, BLK);
      last_rd = cyc;
      reads_q[rd_qid]++;
      if (log_rd) rd_log.push_back(int'(rd_qid));
      rsp_at[cyc + RDL - 1] = rd_qid;
    end
    if (rsp_at.exists(cyc)) begin
      rsp_valid = 1'b1;
      rsp_qid   = rsp_at[cyc];
      for (int i = 0; i < BLK; i++) begin
        rsp_data[i*CW +: CW] = {rsp_qid, IW'(nxt_blk[rsp_qid])};
        nxt_blk[rsp_qid]++;
      end
      rsp_at.delete(cyc);
    end else begin
      rsp_valid = 1'b0;
    end
    req_valid = v;
    req_qid   = QW'(q);
    if (v) begin
      exp_d[cyc + 1 + DEPTH] = {QW'(q), IW'(nxt_dep[q])};
      exp_q[cyc + 1 + DEPTH] = QW'(q);
      nxt_dep[q]++;
      req_q[q]++;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog cyc=%0d got hang exp finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      nxt_dep[q] = 0; nxt_blk[q] = 0; reads_q[q] = 0; req_q[q] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    for (int i = 0; i < 4; i++) begin
      step(0, 0);
      check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    end

    // R5: earliest shortfall first, not lowest id
    log_rd = 1;
    step(1, 0); step(1, 2); step(1, 1);
    for (int i = 0; i < 12; i++) step(0, 0);
    log_rd = 0;
    check(rd_log.size() == 3, "R5", "read count", rd_log.size(), 3);
    if (rd_log.size() == 3) begin
      check(rd_log[0] == 0, "R5", "first read qid", rd_log[0], 0);
      check(rd_log[1] == 2, "R5", "second read qid", rd_log[1], 2);
      check(rd_log[2] == 1, "R5", "third read qid", rd_log[2], 1);
    end
    for (int i = 0; i < DEPTH; i++) step(0, 0);

    // R2 R6 R7: full-rate burst on one queue
    for (int i = 0; i < 40; i++) step(1, 3);
    for (int i = 0; i < 5; i++) step(0, 0);
    // R3: round robin at full rate
    for (int i = 0; i < 60; i++) step(1, i % NQ);
    // sparse pattern with gaps
    for (int i = 0; i < 50; i++) step((i % 3) != 0, (i / 3) % NQ);
    // R7 R8: random stream at full and partial rate
    for (int i = 0; i < 400; i++) step(($urandom % 8) != 0, int'($urandom % NQ));
    // two-queue alternation in pairs
    for (int i = 0; i < 48; i++) step(1, ((i / 2) % 2) * 2 + 1);
    for (int i = 0; i < DEPTH + RDL + 8; i++) step(0, 0);

    // R2: every expected cell appeared
    check(exp_d.size() == 0, "R2", "pending cells", exp_d.size(), 0);
    // R9: exact number of block reads per queue
    for (int q = 0; q < NQ; q++)
      check(reads_q[q] == (req_q[q] + BLK - 1) / BLK, "R9", "reads per queue",
            reads_q[q], (req_q[q] + BLK - 1) / BLK);
    check(rd_valid == 1'b0, "R9", "rd_valid when drained", rd_valid, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule